// File: doc/BRIEF.md
# Dual Input Auto Selector

This block decides which of two serial video receivers, an electrical one and an optical one, drives the receive path. Each receiver supplies a flag saying it currently carries a valid multiplex signal. The block also takes a flag saying the optical receiver is fitted, and a two-bit mode. It returns the index of the chosen input and a status flag that is high while the chosen input is valid.

In the hunting mode the selector has no favourite input. It stays on whichever input it is on for as long as that input is valid. When the current input has been invalid for a programmable number of consecutive cycles (`DWELL_CYCLES`), it tries the other input. This dwell stops short dropouts from causing chatter. In the two forced modes, one input is used whatever the flags say. Without an optical receiver fitted, the electrical input is always used.

Top module: `rx_src_select`

## Requirements
- R1: Reset is asynchronous and active low. While it is asserted and after its release, `sel_o` is 0 (electrical). The selection encoding is 0 = electrical and 1 = optical.
- R2: When `opt_fitted_i` is 0, `sel_o` is 0 after the next clock edge, whatever the mode and flags are. Time spent in this state never counts toward a switch.
- R3: With the optical receiver fitted and `mode_i` = 1, `sel_o` is 0 after the next edge. It stays 0 for as long as that mode is held, even if the electrical flag stays low.
- R4: With the optical receiver fitted and `mode_i` = 2, `sel_o` is 1 after the next edge, whatever the flags are.
- R5: In hunting mode (`mode_i` = 0), `sel_o` holds while the currently selected input's flag is high, even when the other input is also valid.
- R6: In hunting mode, `sel_o` toggles on the clock edge that samples the DWELL_CYCLES-th consecutive cycle in which the selected input's flag is low. A dropout that is shorter than this restarts the count and leaves `sel_o` unchanged.
- R7: In hunting mode with both flags low, `sel_o` alternates once every DWELL_CYCLES cycles.
- R8: `mode_i` = 3 behaves exactly like `mode_i` = 0.
- R9: `link_ok_o` is combinationally equal to the flag of the input named by `sel_o`. A change of that flag shows without a clock edge.
- R10: Any cycle spent outside hunting mode clears the dwell count. On return to hunting, a full DWELL_CYCLES of invalid cycles is needed before a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| elec_ok_i | input | 1 | Electrical input carries a valid multiplex |
| opt_ok_i | input | 1 | Optical input carries a valid multiplex |
| opt_fitted_i | input | 1 | Optical receiver is installed |
| mode_i | input | 2 | 0/3 hunt, 1 force electrical, 2 force optical |
| sel_o | output | 1 | Chosen input: 0 electrical, 1 optical |
| link_ok_o | output | 1 | Chosen input currently valid |

## Verification
The bench targets the dwell boundary. It checks that a loss of DWELL_CYCLES-1 cycles leaves the selection alone and that one more cycle moves it, so an off-by-one counter switches a cycle early or late. It recovers the current input after a short dropout, so a counter that does not restart would switch too early later on. It holds the second input valid while the first is also valid, so a design with a hidden priority would jump without cause. It also leaves hunting mode in the middle of a count and checks that the count starts again from zero, sets mode 3, and removes the optical receiver while a forced optical mode is active. A design that ignores the fitted flag would keep reporting optical.

// File: rtl/rx_src_select_pkg.sv
package rx_src_select_pkg;

  typedef enum logic [1:0] {
    MODE_HUNT     = 2'd0,
    MODE_ELEC     = 2'd1,
    MODE_OPT      = 2'd2,
    MODE_HUNT_ALT = 2'd3
  } rxs_mode_e;

  typedef enum logic [1:0] {
    POL_FORCE_ELEC = 2'd0,
    POL_FORCE_OPT  = 2'd1,
    POL_HUNT       = 2'd2
  } rxs_policy_e;

  localparam logic SEL_ELEC = 1'b0;
  localparam logic SEL_OPT  = 1'b1;

endpackage

// File: rtl/rx_src_policy.sv
module rx_src_policy
  import rx_src_select_pkg::*;
(
  input  logic        opt_fitted_i,
  input  logic [1:0]  mode_i,
  output rxs_policy_e policy_o
);

  rxs_mode_e mode;

  assign mode = rxs_mode_e'(mode_i);

  always_comb begin
    if (!opt_fitted_i) begin
      policy_o = POL_FORCE_ELEC;       // R2: no optical receiver
    end else begin
      unique case (mode)
        MODE_ELEC: policy_o = POL_FORCE_ELEC;
        MODE_OPT:  policy_o = POL_FORCE_OPT;
        default:   policy_o = POL_HUNT; // R8: code 3 hunts too
      endcase
    end
  end

endmodule

// File: rtl/rx_src_dwell.sv
module rx_src_dwell #(
  parameter int unsigned DWELL_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,     // selected input invalid while hunting
  output logic expire_o   // final invalid cycle of the dwell window
);

  generate
    if (DWELL_CYCLES <= 1) begin : g_nodwell
      assign expire_o = run_i;
    end else begin : g_count
      localparam int unsigned CW    = $clog2(DWELL_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(DWELL_CYCLES - 1);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign expire_o = run_i && (cnt_q == LAST);

      always_comb begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
        if (!run_i || expire_o) begin
          cnt_d  = '0;               // R10: cleared outside the window
          cnt_en = (cnt_q != '0);
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/rx_src_select.sv
module rx_src_select
  import rx_src_select_pkg::*;
#(
  parameter int unsigned DWELL_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       elec_ok_i,
  input  logic       opt_ok_i,
  input  logic       opt_fitted_i,
  input  logic [1:0] mode_i,
  output logic       sel_o,
  output logic       link_ok_o
);

  rxs_policy_e policy;
  logic        sel_q, sel_d, sel_en;
  logic        cur_ok;
  logic        hunt_run;
  logic        dwell_done;

  rx_src_policy u_policy (
    .opt_fitted_i (opt_fitted_i),
    .mode_i       (mode_i),
    .policy_o     (policy)
  );

  assign cur_ok   = (sel_q == SEL_OPT) ? opt_ok_i : elec_ok_i;
  assign hunt_run = (policy == POL_HUNT) && !cur_ok;

  rx_src_dwell #(
    .DWELL_CYCLES (DWELL_CYCLES)
  ) u_dwell (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .run_i    (hunt_run),
    .expire_o (dwell_done)
  );

  always_comb begin
    sel_d = sel_q;
    unique case (policy)
      POL_FORCE_ELEC: sel_d = SEL_ELEC;
      POL_FORCE_OPT:  sel_d = SEL_OPT;
      default:        sel_d = dwell_done ? ~sel_q : sel_q;
    endcase
    sel_en = (sel_d != sel_q);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sel_q <= SEL_ELEC;               // R1
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign sel_o     = sel_q;
  assign link_ok_o = cur_ok;           // R9

endmodule

// File: rtl/rx_src_select_chk.sv
module rx_src_select_chk #(
  parameter int unsigned DWELL_CYCLES = 16
) (
  input logic       clk_i,
  input logic       rst_n_i,
  input logic       elec_ok_i,
  input logic       opt_ok_i,
  input logic       opt_fitted_i,
  input logic [1:0] mode_i,
  input logic       sel_o,
  input logic       link_ok_o
);

  localparam int unsigned LAST = (DWELL_CYCLES > 0) ? DWELL_CYCLES - 1 : 0;

  logic        hunting, seen_ok, lost;
  int unsigned lost_cnt;

  assign hunting = opt_fitted_i && (mode_i == 2'd0 || mode_i == 2'd3);
  assign seen_ok = sel_o ? opt_ok_i : elec_ok_i;
  assign lost    = hunting && !seen_ok;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lost_cnt <= 0;
    end else if (!lost || lost_cnt >= LAST) begin
      lost_cnt <= 0;
    end else begin
      lost_cnt <= lost_cnt + 1;
    end
  end

  a_r2_unfitted_elec: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !opt_fitted_i |=> !sel_o);

  a_r3_forced_elec: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (opt_fitted_i && mode_i == 2'd1) |=> !sel_o);

  a_r4_forced_opt: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (opt_fitted_i && mode_i == 2'd2) |=> sel_o);

  a_r5_hold_while_valid: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (hunting && seen_ok) |=> $stable(sel_o));

  a_r6_no_early_switch: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (lost && lost_cnt < LAST) |=> $stable(sel_o));

  a_r6_switch_at_dwell: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (lost && lost_cnt >= LAST) |=> (sel_o != $past(sel_o)));

  a_r9_status_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    link_ok_o |-> (elec_ok_i || opt_ok_i));

endmodule

bind rx_src_select rx_src_select_chk #(
  .DWELL_CYCLES (DWELL_CYCLES)
) chk_i (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .elec_ok_i    (elec_ok_i),
  .opt_ok_i     (opt_ok_i),
  .opt_fitted_i (opt_fitted_i),
  .mode_i       (mode_i),
  .sel_o        (sel_o),
  .link_ok_o    (link_ok_o)
);

// File: tb/rx_src_select_tb_top.sv
`timescale 1ns/1ps
module rx_src_select_tb_top;

  localparam int unsigned DWELL = 4;
  localparam int NVEC = 35;

  // vector bits: fitted, mode[1:0], elec_ok, opt_ok, exp_sel, exp_ok
  localparam logic [6:0] VEC [0:NVEC-1] = '{
    7'b1_01_01_00, 7'b1_01_01_00, 7'b1_01_01_00, 7'b1_01_01_00, 7'b1_01_01_00, // R3
    7'b1_10_10_10, 7'b1_10_10_10,                                              // R4
    7'b0_10_01_00, 7'b0_00_01_00, 7'b0_00_01_00, 7'b0_00_01_00,               // R2
    7'b0_00_01_00, 7'b0_00_01_00,
    7'b1_00_11_01, 7'b1_00_01_00, 7'b1_00_01_00, 7'b1_00_11_01,               // R6 short dropout
    7'b1_00_01_00, 7'b1_00_01_00, 7'b1_00_01_00, 7'b1_00_01_11,               // R6 switch
    7'b1_00_11_11, 7'b1_00_11_11,                                              // R5
    7'b1_11_10_10, 7'b1_11_10_10, 7'b1_11_10_10, 7'b1_11_10_01,               // R8
    7'b1_00_00_00, 7'b1_00_00_00, 7'b1_00_00_00, 7'b1_00_00_10,               // R7
    7'b1_00_00_10, 7'b1_00_00_10, 7'b1_00_00_10, 7'b1_00_00_00
  };

  logic       clk_i = 1'b0;
  logic       rst_n_i;
  logic       elec_ok_i, opt_ok_i, opt_fitted_i;
  logic [1:0] mode_i;
  logic       sel_o, link_ok_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  rx_src_select #(.DWELL_CYCLES(DWELL)) dut_i (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .elec_ok_i    (elec_ok_i),
    .opt_ok_i     (opt_ok_i),
    .opt_fitted_i (opt_fitted_i),
    .mode_i       (mode_i),
    .sel_o        (sel_o),
    .link_ok_o    (link_ok_o)
  );

  task automatic check(input string req, input logic as, input logic es,
                       input logic al, input logic el);
    checks++;
    if (as !== es || al !== el) begin
      fails++;
      $display("FAIL %s sel=%b ok=%b expected sel=%b ok=%b", req, as, al, es, el);
    end
  endtask

  task automatic apply(input logic f, input logic [1:0] m, input logic e, input logic o);
    @(negedge clk_i);
    opt_fitted_i = f; mode_i = m; elec_ok_i = e; opt_ok_i = o;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    rst_n_i = 1'b0; opt_fitted_i = 1'b1; mode_i = 2'd0;
    elec_ok_i = 1'b1; opt_ok_i = 1'b0;
    #20;
    check("R1 in reset", sel_o, 1'b0, link_ok_o, 1'b1);
    @(negedge clk_i); rst_n_i = 1'b1;
    tick();
    check("R1 after release", sel_o, 1'b0, link_ok_o, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][6], VEC[i][5:4], VEC[i][3], VEC[i][2]);
      tick();
      check($sformatf("vector %0d (R2-R8)", i), sel_o, VEC[i][1], link_ok_o, VEC[i][0]);
    end

    // R9: status follows the selected flag with no clock edge
    @(negedge clk_i); elec_ok_i = 1'b1;
    #1 check("R9 rise", sel_o, 1'b0, link_ok_o, 1'b1);
    opt_ok_i = 1'b1;
    #1 check("R9 other flag", sel_o, 1'b0, link_ok_o, 1'b1);
    elec_ok_i = 1'b0;
    #1 check("R9 fall", sel_o, 1'b0, link_ok_o, 1'b0);

    // R10: leaving hunting mode mid-count clears the dwell
    apply(1'b1, 2'd0, 1'b1, 1'b0); tick();
    for (int k = 0; k < 3; k++) begin
      apply(1'b1, 2'd0, 1'b0, 1'b0); tick();
    end
    check("R10 pre-interrupt", sel_o, 1'b0, link_ok_o, 1'b0);
    apply(1'b1, 2'd1, 1'b0, 1'b0); tick();
    for (int k = 0; k < 3; k++) begin
      apply(1'b1, 2'd0, 1'b0, 1'b0); tick();
      check("R10 count restarted", sel_o, 1'b0, link_ok_o, 1'b0);
    end
    apply(1'b1, 2'd0, 1'b0, 1'b1); tick();
    check("R10 full dwell switches", sel_o, 1'b1, link_ok_o, 1'b1);

    // R1: asynchronous reset from the optical side
    @(negedge clk_i); rst_n_i = 1'b0;
    #1 check("R1 async clear", sel_o, 1'b0, link_ok_o, 1'b0);
    @(negedge clk_i); rst_n_i = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule